// File: doc/BRIEF.md
# Bounds-Checked Base Register File

This block keeps a small bank of base registers. Each register holds a base word address together with the inclusive lowest and highest page numbers of the page group it currently covers. Typical slots are the program-global pointer, the module-code pointer, the module own-data pointer, the current frame pointer and a few pointers that user code computes. On an access the caller supplies a register index and a word offset. The block adds the offset to that register's base and tests the page of the result against the register's bounds. One cycle later it reports either the finished address or a fault.

After a fault the block stops taking accesses until software performs a bounds reload. A bounds reload writes the base and both bounds in one step. There is also a cheaper reload that rewrites only the base. A procedure call that moves the frame inside the same page group uses this base-only reload, and it records no fault. Each register has its own saturating fault counter. Any one counter can be read through a select input.

The control logic is a two-state machine. `ST_OPEN` accepts accesses. `ST_HOLD` waits for a bounds reload after a fault. The transition `ST_OPEN -> ST_HOLD` happens when an accepted access misses its bounds. The transition `ST_HOLD -> ST_OPEN` happens on any bounds-reload strobe.

Top module: `bound_base_regs`

## Requirements
- R1: After reset every register has base 0 and bounds 0..0, every fault counter reads 0, `acc_ready` is high, and `acc_done` and `flt_pulse` are low.
- R2: An accepted access (`acc_valid` high while `acc_ready` is high) whose address is in bounds raises `acc_done` for exactly one cycle, one clock after acceptance. `acc_addr` then equals (base + offset) modulo 2^16.
- R3: The page of an address is the address shifted right by 8 + log2(GROUP_FACTOR), so bits [15:8] with the default factor of 1. An accepted access whose page lies below the low bound or above the high bound raises `flt_pulse` one clock after acceptance, with `flt_idx` and `flt_addr` set to the index and the address. `acc_done` stays low in that cycle.
- R4: From the fault cycle onward `acc_ready` is low and accesses are ignored, producing neither `acc_done` nor `flt_pulse`. A cycle with `bnd_wr` high returns `acc_ready` to high on the next clock.
- R5: A base-only reload (`base_wr`) replaces the base of the selected register and leaves its bounds and its fault counter unchanged.
- R6: A bounds reload (`bnd_wr`) writes base, low page and high page of the selected register together. When both reloads target the same register in one cycle, the bounds reload wins.
- R7: The fault counter of a register rises by one on each fault of that register and holds at its maximum value (2^CNT_W - 1). Nothing else changes it. `cnt_value` shows the counter chosen by `cnt_sel`.
- R8: A reload or a fault on one register leaves every other register's contents and counter unchanged.
- R9: An access accepted in the same cycle as a reload of its register uses the contents from before that reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_idx | input | IDX_W | Register used by the access |
| acc_off | input | AW | Word offset added to the base |
| acc_ready | output | 1 | High when accesses are accepted |
| acc_done | output | 1 | Access completed in bounds (one-cycle pulse) |
| acc_addr | output | AW | Effective address of the completed access |
| flt_pulse | output | 1 | Bounds fault (one-cycle pulse) |
| flt_idx | output | IDX_W | Register that faulted |
| flt_addr | output | AW | Address that faulted |
| base_wr | input | 1 | Base-only reload strobe |
| base_idx | input | IDX_W | Register for base-only reload |
| base_val | input | AW | New base value |
| bnd_wr | input | 1 | Bounds reload strobe (base plus bounds) |
| bnd_idx | input | IDX_W | Register for bounds reload |
| bnd_base | input | AW | New base value |
| bnd_lo | input | PW | New inclusive low page |
| bnd_hi | input | PW | New inclusive high page |
| cnt_sel | input | IDX_W | Fault counter to show |
| cnt_value | output | CNT_W | Selected fault counter |

## Verification
The hardest case to reach from the ports is a counter at saturation. With 32-bit counters it cannot be reached in practice, so the bench builds the block with a 3-bit counter. It then forces nine fault-and-reload rounds on one register and checks that the counter stops at 7. Ordering corners need inputs lined up in a single cycle: an access together with a reload of the same register, both reload kinds aimed at one register, and accesses sent while the block waits for a reload. The scoreboard expects no output at all for those ignored accesses.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } bbr_state_e;
endpackage

// File: rtl/bbr_regfile.sv
module bbr_regfile #(
    parameter int NREG  = 8,
    parameter int IDX_W = 3,
    parameter int AW    = 16,
    parameter int PW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [AW-1:0]    base_val,
    input  logic             bnd_wr,
    input  logic [IDX_W-1:0] bnd_idx,
    input  logic [AW-1:0]    bnd_base,
    input  logic [PW-1:0]    bnd_lo,
    input  logic [PW-1:0]    bnd_hi,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_base,
    output logic [PW-1:0]    rd_lo,
    output logic [PW-1:0]    rd_hi
);
    logic [AW-1:0] base_q [NREG];
    logic [PW-1:0] lo_q   [NREG];
    logic [PW-1:0] hi_q   [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                lo_q[i]   <= '0;
                hi_q[i]   <= '0;
            end else if (bnd_wr && (bnd_idx == IDX_W'(i))) begin
                base_q[i] <= bnd_base;
                lo_q[i]   <= bnd_lo;
                hi_q[i]   <= bnd_hi;
            end else if (base_wr && (base_idx == IDX_W'(i))) begin
                base_q[i] <= base_val;
            end
        end
    end

    always_comb begin
        rd_base = base_q[rd_idx];
        rd_lo   = lo_q[rd_idx];
        rd_hi   = hi_q[rd_idx];
    end
endmodule

// File: rtl/bbr_range_chk.sv
module bbr_range_chk #(
    parameter int AW     = 16,
    parameter int PSHIFT = 8,
    parameter int PW     = 8
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] off,
    input  logic [PW-1:0] lo,
    input  logic [PW-1:0] hi,
    output logic [AW-1:0] ea,
    output logic          miss
);
    logic [PW-1:0] page;

    always_comb begin
        ea   = base + off;
        page = ea[AW-1:PSHIFT];
        miss = (page < lo) || (page > hi);
    end
endmodule

// File: rtl/bbr_fault_ctr.sv
module bbr_fault_ctr #(
    parameter int NREG  = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [IDX_W-1:0] rd_sel,
    output logic [CNT_W-1:0] rd_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[i] <= '0;
            end else if (inc && (inc_idx == IDX_W'(i)) && (cnt_q[i] != CNT_MAX)) begin
                cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end
    end

    assign rd_val = cnt_q[rd_sel];
endmodule

// File: rtl/bound_base_regs.sv
module bound_base_regs
    import bbr_pkg::*;
#(
    parameter int NREG         = 8,
    parameter int IDX_W        = $clog2(NREG),
    parameter int AW           = 16,
    parameter int GROUP_FACTOR = 1,
    parameter int PW           = AW - 8 - $clog2(GROUP_FACTOR),
    parameter int CNT_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [AW-1:0]    acc_off,
    output logic             acc_ready,
    output logic             acc_done,
    output logic [AW-1:0]    acc_addr,
    output logic             flt_pulse,
    output logic [IDX_W-1:0] flt_idx,
    output logic [AW-1:0]    flt_addr,
    input  logic             base_wr,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [AW-1:0]    base_val,
    input  logic             bnd_wr,
    input  logic [IDX_W-1:0] bnd_idx,
    input  logic [AW-1:0]    bnd_base,
    input  logic [PW-1:0]    bnd_lo,
    input  logic [PW-1:0]    bnd_hi,
    input  logic [IDX_W-1:0] cnt_sel,
    output logic [CNT_W-1:0] cnt_value
);
    localparam int PSHIFT = AW - PW;

    bbr_state_e    state_q, state_d;
    logic [AW-1:0] cur_base;
    logic [PW-1:0] cur_lo, cur_hi;
    logic [AW-1:0] ea;
    logic          miss;
    logic          take;

    assign take = acc_valid && (state_q == ST_OPEN);

    bbr_regfile #(.NREG(NREG), .IDX_W(IDX_W), .AW(AW), .PW(PW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_wr  (base_wr),
        .base_idx (base_idx),
        .base_val (base_val),
        .bnd_wr   (bnd_wr),
        .bnd_idx  (bnd_idx),
        .bnd_base (bnd_base),
        .bnd_lo   (bnd_lo),
        .bnd_hi   (bnd_hi),
        .rd_idx   (acc_idx),
        .rd_base  (cur_base),
        .rd_lo    (cur_lo),
        .rd_hi    (cur_hi)
    );

    bbr_range_chk #(.AW(AW), .PSHIFT(PSHIFT), .PW(PW)) u_chk_rng (
        .base (cur_base),
        .off  (acc_off),
        .lo   (cur_lo),
        .hi   (cur_hi),
        .ea   (ea),
        .miss (miss)
    );

    bbr_fault_ctr #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (take && miss),
        .inc_idx (acc_idx),
        .rd_sel  (cnt_sel),
        .rd_val  (cnt_value)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (take && miss) state_d = ST_HOLD;
            ST_HOLD: if (bnd_wr)       state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    assign acc_ready = (state_q == ST_OPEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_done  <= 1'b0;
            acc_addr  <= '0;
            flt_pulse <= 1'b0;
            flt_idx   <= '0;
            flt_addr  <= '0;
        end else begin
            acc_done  <= take && !miss;
            flt_pulse <= take && miss;
            if (take && !miss) acc_addr <= ea;
            if (take && miss) begin
                flt_idx  <= acc_idx;
                flt_addr <= ea;
            end
        end
    end
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
    parameter int IDX_W = 3,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_ready,
    input logic             acc_done,
    input logic             flt_pulse,
    input logic             bnd_wr,
    input logic [IDX_W-1:0] flt_idx,
    input logic [IDX_W-1:0] cnt_sel,
    input logic [CNT_W-1:0] cnt_value
);
    assert_done_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> (acc_done || flt_pulse));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_ready) |=> (!acc_done && !flt_pulse));

    assert_excl_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_done && flt_pulse));

    assert_hold_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pulse |-> !acc_ready);

    assert_hold_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ready && !bnd_wr) |=> !acc_ready);

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ready && bnd_wr) |=> acc_ready);

    assert_cnt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cnt_sel) && !flt_pulse) |-> $stable(cnt_value));

    assert_cnt_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cnt_sel) && flt_pulse && (flt_idx == cnt_sel)) |-> (cnt_value >= $past(cnt_value)));
endmodule

bind bound_base_regs bbr_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_bbr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .acc_done  (acc_done),
    .flt_pulse (flt_pulse),
    .bnd_wr    (bnd_wr),
    .flt_idx   (flt_idx),
    .cnt_sel   (cnt_sel),
    .cnt_value (cnt_value)
);

// File: tb/bound_base_regs_bench.sv
module bound_base_regs_bench;
    localparam int IDX_W = 3;
    localparam int AW    = 16;
    localparam int PW    = 8;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_idx = '0;
    logic [AW-1:0]    acc_off = '0;
    logic             acc_ready, acc_done, flt_pulse;
    logic [AW-1:0]    acc_addr, flt_addr;
    logic [IDX_W-1:0] flt_idx;
    logic             base_wr = 1'b0;
    logic [IDX_W-1:0] base_idx = '0;
    logic [AW-1:0]    base_val = '0;
    logic             bnd_wr = 1'b0;
    logic [IDX_W-1:0] bnd_idx = '0;
    logic [AW-1:0]    bnd_base = '0;
    logic [PW-1:0]    bnd_lo = '0, bnd_hi = '0;
    logic [IDX_W-1:0] cnt_sel = '0;
    logic [CNT_W-1:0] cnt_value;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    bound_base_regs #(.NREG(8), .AW(AW), .GROUP_FACTOR(1), .CNT_W(CNT_W)) u_bound_base_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_off(acc_off),
        .acc_ready(acc_ready), .acc_done(acc_done), .acc_addr(acc_addr),
        .flt_pulse(flt_pulse), .flt_idx(flt_idx), .flt_addr(flt_addr),
        .base_wr(base_wr), .base_idx(base_idx), .base_val(base_val),
        .bnd_wr(bnd_wr), .bnd_idx(bnd_idx), .bnd_base(bnd_base),
        .bnd_lo(bnd_lo), .bnd_hi(bnd_hi),
        .cnt_sel(cnt_sel), .cnt_value(cnt_value)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per result
    always @(posedge clk) begin
        #1;
        if (rst_n && (acc_done || flt_pulse)) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected result", {11'd0, flt_pulse, flt_idx, (flt_pulse ? flt_addr : acc_addr)}, 32'hFFFF_FFFF);
            end else begin
                logic [19:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (flt_pulse) check(t, {12'd0, 1'b1, flt_idx, flt_addr}, {12'd0, e});
                else           check(t, {12'd0, 1'b0, 3'd0, acc_addr}, {12'd0, e});
            end
        end
    end

    task automatic access(input logic [2:0] idx, input logic [15:0] off,
                          input bit fault, input logic [15:0] addr, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = idx; acc_off = off;
        exp_q.push_back({fault, (fault ? idx : 3'd0), addr});
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic ignored_access(input logic [2:0] idx, input logic [15:0] off);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = idx; acc_off = off;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic load_bounds(input logic [2:0] idx, input logic [15:0] b,
                               input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        bnd_wr = 1'b1; bnd_idx = idx; bnd_base = b; bnd_lo = lo; bnd_hi = hi;
        @(negedge clk);
        bnd_wr = 1'b0;
    endtask

    task automatic load_base(input logic [2:0] idx, input logic [15:0] b);
        @(negedge clk);
        base_wr = 1'b1; base_idx = idx; base_val = b;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic check_cnt(input logic [2:0] idx, input int exp, input string tag);
        @(negedge clk);
        cnt_sel = idx;
        #0.5;
        check(tag, {29'd0, cnt_value}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, acc_ready}, 1);
        check("R1 no done after reset", {31'd0, acc_done}, 0);
        check("R1 no fault after reset", {31'd0, flt_pulse}, 0);
        for (int i = 0; i < 8; i++) check_cnt(i[2:0], 0, "R1 counter zero");

        access(3'd0, 16'h0010, 0, 16'h0010, "R1 reset bounds page 0");
        access(3'd0, 16'h0100, 1, 16'h0100, "R1 reset bounds exclude page 1");
        load_bounds(3'd0, 16'h0000, 8'h00, 8'h00);

        load_bounds(3'd2, 16'h1200, 8'h12, 8'h13);
        access(3'd2, 16'h0150, 0, 16'h1350, "R2 R6 in bounds address");
        access(3'd2, 16'h0200, 1, 16'h1400, "R3 above high bound");
        @(negedge clk);
        check("R4 ready low after fault", {31'd0, acc_ready}, 0);
        ignored_access(3'd2, 16'h0000);
        ignored_access(3'd1, 16'h0000);
        check_cnt(3'd2, 1, "R7 count after fault");
        check_cnt(3'd0, 1, "R8 other counter untouched");
        load_bounds(3'd2, 16'h1400, 8'h14, 8'h14);
        check("R4 ready after bounds reload", {31'd0, acc_ready}, 1);
        access(3'd2, 16'h00FF, 0, 16'h14FF, "R2 top of group");

        load_base(3'd2, 16'h1480);
        access(3'd2, 16'h0010, 0, 16'h1490, "R5 base-only reload in group");
        check_cnt(3'd2, 1, "R5 base reload leaves counter");
        load_base(3'd2, 16'h1500);
        access(3'd2, 16'h0000, 1, 16'h1500, "R5 bounds kept after base reload");
        check_cnt(3'd2, 2, "R7 second fault");
        load_bounds(3'd2, 16'h1500, 8'h15, 8'h15);

        // R6 precedence of bounds reload over base-only reload
        @(negedge clk);
        base_wr = 1'b1; base_idx = 3'd3; base_val = 16'h0777;
        bnd_wr = 1'b1; bnd_idx = 3'd3; bnd_base = 16'h3000; bnd_lo = 8'h30; bnd_hi = 8'h30;
        @(negedge clk);
        base_wr = 1'b0; bnd_wr = 1'b0;
        access(3'd3, 16'h0005, 0, 16'h3005, "R6 bounds reload wins");

        // R9 access with same-cycle reload uses old contents
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 3'd3; acc_off = 16'h0000;
        exp_q.push_back({1'b0, 3'd0, 16'h3000}); tag_q.push_back("R9 old contents used");
        bnd_wr = 1'b1; bnd_idx = 3'd3; bnd_base = 16'h5000; bnd_lo = 8'h50; bnd_hi = 8'h50;
        @(negedge clk);
        acc_valid = 1'b0; bnd_wr = 1'b0;
        access(3'd3, 16'h0000, 0, 16'h5000, "R9 new contents afterwards");
        access(3'd0, 16'h0020, 0, 16'h0020, "R8 register 0 unchanged");

        // R2 wrap-around
        load_bounds(3'd4, 16'hFF00, 8'h00, 8'hFF);
        access(3'd4, 16'h0200, 0, 16'h0100, "R2 address wraps");

        // R3 below low bound and R7 saturation
        load_bounds(3'd5, 16'h0000, 8'h10, 8'h10);
        for (int k = 0; k < 9; k++) begin
            access(3'd5, 16'h0000, 1, 16'h0000, "R3 below low bound");
            load_bounds(3'd5, 16'h0000, 8'h10, 8'h10);
        end
        check_cnt(3'd5, 7, "R7 counter saturates");
        check_cnt(3'd2, 2, "R8 counter of register 2 kept");

        repeat (4) @(negedge clk);
        check("R2 all results seen", exp_q.size(), 0);
        done_run = 1'b1;
    end

    initial begin
        fork
            begin wait (done_run); end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule